// File: doc/BRIEF.md
# Layered Min-Sum LDPC Decoder Core

This block decodes one frame of a small quasi-cyclic LDPC code whose parity part is an accumulator chain: every parity block column is shared by two neighbouring block rows, so the parity bits form a dual-diagonal chain that wraps round. Soft input values arrive one per beat on a valid/ready stream. The core stores them as posterior values and then sweeps the block rows in a fixed order for a set number of iterations. The Z check rows of one circulant block row are handled side by side in Z lanes.

Each check row subtracts its old check-to-variable message from the posteriors it touches. It finds the smallest and second-smallest magnitude and the sign product, using min-sum with no nonlinear function. It then writes the new posteriors back before the next block row starts, so later rows of the same iteration already see the refreshed values. Each row keeps its message in compressed form: two magnitudes, the position of the smaller one, and one sign per edge.

After the last iteration the core raises a one-cycle completion pulse. It then streams the hard decisions out, Z bits per beat, on a second valid/ready stream. The input stream is closed (ready low) from the last accepted value until the last output beat has been taken. The output stream holds its data for as long as the consumer stalls.

Top module: `ldpc_layer_dec`

## Requirements
- R1: `in_ready` is high exactly while the core is collecting a frame. A value is taken on each cycle with `in_valid` and `in_ready` both high, and values are taken in variable order 0 to N-1, where N = (4+MB)*Z. Once the N-th value is taken, `in_ready` stays low, and any `in_valid` traffic is ignored until the frame's last output beat is accepted.
- R2: The hard decision of a variable is the sign bit of its final posterior: 1 for a negative posterior, 0 for zero or positive.
- R3: Input values are 6-bit two's complement, sign-extended into 8-bit posteriors. Every posterior, and every posterior-minus-message value, saturates to the symmetric range -127 to +127.
- R4: A row's outgoing magnitude to an edge is the second-smallest input magnitude if that edge is the first edge holding the smallest, and the smallest otherwise. Its sign is the XOR of all the row's input signs with the edge's own sign. A zero input counts as positive. Before the first iteration of every frame, all messages are zero.
- R5: Block rows are updated in order 0 to MB-1 in each iteration. A row reads posteriors already written by earlier rows of the same iteration. Edges within a row are visited in order 0 to 5.
- R6: Check row z of block row r has six edges. For edge c in 0..3 it connects to variable c*Z + ((z + (r*(c+1)+c) mod Z) mod Z). Edge 4 connects to variable (4+r)*Z + z. Edge 5 connects to variable (4+((r+MB-1) mod MB))*Z + z.
- R7: Decoding runs exactly ITERS iterations. `done` and the first output beat appear exactly ITERS*MB*12 cycles after the clock edge that takes the last input value.
- R8: Output beat k (k = 0 to 3+MB) carries bit z = decision of variable k*Z+z, with `out_last` high on beat 3+MB only. While `out_valid` is high and `out_ready` is low, the data and `out_last` hold. After the last beat is accepted, `in_ready` is high on the next cycle.
- R9: `done` is high for exactly one cycle, the first cycle in which `out_valid` is high.
- R10: Frames are independent: the same input frame always yields the same decisions, whatever frame came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Core is collecting a frame |
| in_llr | input | 6 | Soft input value, two's complement, positive favours bit 0 |
| out_valid | output | 1 | Decision beat offered |
| out_ready | input | 1 | Consumer takes the beat |
| out_bits | output | Z | Hard decisions of one block column |
| out_last | output | 1 | Final beat of the frame |
| done | output | 1 | One-cycle pulse at the end of decoding |

## Verification
The completion pulse and the first decision beat are due ITERS*MB*12 cycles after the edge that takes the last input value. The bench records the cycle count at the falling edge after that acceptance and compares it with the count at the falling edge where `out_valid` first shows. Each decision beat is due on the falling edge before the rising edge that accepts it. The bench drives `out_ready` at falling edges, compares each accepted beat against a bit-exact software model of the sweep, and checks that a stalled beat is unchanged one cycle later. During decoding it keeps `in_valid` high with noise, to show that the closed input stream disturbs nothing.

// File: rtl/ldpc_layer_pkg.sv
package ldpc_layer_pkg;
  localparam int LLR_W  = 6;
  localparam int POST_W = 8;
  localparam int MAG_W  = POST_W - 1;
  localparam int ROW_W  = 6;                  // four info edges plus two chain edges
  localparam int INFO_E = ROW_W - 2;
  localparam int EW     = $clog2(ROW_W);
  localparam int SUM_W  = POST_W + 2;

  typedef logic signed [POST_W-1:0] post_t;
  typedef logic signed [SUM_W-1:0]  sum_t;
  typedef logic [MAG_W-1:0]         mag_t;

  typedef struct packed {
    mag_t             lo1;
    mag_t             lo2;
    logic [EW-1:0]    lo_pos;
    logic [ROW_W-1:0] neg;
  } cmsg_t;

  localparam sum_t PMAX = SUM_W'(2 ** (POST_W - 1) - 1);
  localparam sum_t PMIN = -PMAX;

  function automatic post_t clamp_post(input sum_t x);
    if (x > PMAX) return PMAX[POST_W-1:0];
    if (x < PMIN) return PMIN[POST_W-1:0];
    return x[POST_W-1:0];
  endfunction

  function automatic sum_t widen(input post_t p);
    return $signed({{(SUM_W-POST_W){p[POST_W-1]}}, p});
  endfunction

  function automatic sum_t signed_mag(input mag_t m, input logic n);
    sum_t v;
    v = $signed({{(SUM_W-MAG_W){1'b0}}, m});
    return n ? (-v) : v;
  endfunction
endpackage

// File: rtl/ldpc_layer_rom.sv
module ldpc_layer_rom
  import ldpc_layer_pkg::*;
#(
  parameter int Z  = 4,
  parameter int MB = 4
) (
  input  logic [((MB > 1) ? $clog2(MB) : 1)-1:0]          brow,
  input  logic [EW-1:0]                                    eidx,
  output logic [$clog2(INFO_E + MB)-1:0]                   bcol,
  output logic [((Z > 1) ? $clog2(Z) : 1)-1:0]             shift
);
  localparam int NB   = INFO_E + MB;
  localparam int CB_W = $clog2(NB);
  localparam int ZW   = (Z > 1) ? $clog2(Z) : 1;

  always_comb begin
    int r;
    int e;
    r = int'(brow);
    e = int'(eidx);
    if (e < INFO_E) begin
      bcol  = CB_W'(e);
      shift = ZW'((r * (e + 1) + e) % Z);
    end else if (e == INFO_E) begin
      bcol  = CB_W'(INFO_E + r);
      shift = '0;
    end else begin
      bcol  = CB_W'(INFO_E + ((r + MB - 1) % MB));
      shift = '0;
    end
  end
endmodule

// File: rtl/ldpc_layer_lane.sv
module ldpc_layer_lane
  import ldpc_layer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phase_a,
  input  logic          phase_b,
  input  logic [EW-1:0] eidx,
  input  post_t         post_in,
  input  cmsg_t         msg_old,
  output post_t         post_out,
  output cmsg_t         msg_new
);
  post_t qbuf [ROW_W];
  cmsg_t trk_q;
  cmsg_t trk_prev;
  cmsg_t trk_nxt;
  post_t q_val;
  mag_t  q_mag;
  logic  q_neg;
  mag_t  old_mag;
  logic  old_neg;
  mag_t  new_mag;
  logic  new_neg;
  logic [POST_W-1:0] q_flip;

  // phase A: strip old message, track the two minima
  always_comb begin
    old_mag = (eidx == msg_old.lo_pos) ? msg_old.lo2 : msg_old.lo1;
    old_neg = (^msg_old.neg) ^ msg_old.neg[eidx];
    q_val   = clamp_post(widen(post_in) - signed_mag(old_mag, old_neg));
    q_neg   = q_val[POST_W-1];
    q_flip  = POST_W'(0) - q_val;
    q_mag   = q_neg ? q_flip[MAG_W-1:0] : q_val[MAG_W-1:0];

    if (eidx == '0) begin
      trk_prev.lo1    = '1;
      trk_prev.lo2    = '1;
      trk_prev.lo_pos = '0;
      trk_prev.neg    = '0;
    end else begin
      trk_prev = trk_q;
    end
    trk_nxt = trk_prev;
    trk_nxt.neg[eidx] = q_neg;
    if (q_mag < trk_prev.lo1) begin
      trk_nxt.lo2    = trk_prev.lo1;
      trk_nxt.lo1    = q_mag;
      trk_nxt.lo_pos = eidx;
    end else if (q_mag < trk_prev.lo2) begin
      trk_nxt.lo2 = q_mag;
    end
  end

  // phase B: rebuild the outgoing message and refresh the posterior
  always_comb begin
    new_mag  = (eidx == trk_q.lo_pos) ? trk_q.lo2 : trk_q.lo1;
    new_neg  = (^trk_q.neg) ^ trk_q.neg[eidx];
    post_out = clamp_post(widen(qbuf[eidx]) + signed_mag(new_mag, new_neg));
  end

  assign msg_new = trk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q <= '0;
      for (int i = 0; i < ROW_W; i++) qbuf[i] <= '0;
    end else if (phase_a) begin
      trk_q       <= trk_nxt;
      qbuf[eidx]  <= q_val;
    end
  end

  logic unused_b;
  assign unused_b = phase_b;
endmodule

// File: rtl/ldpc_layer_ctrl.sv
module ldpc_layer_ctrl
  import ldpc_layer_pkg::*;
#(
  parameter int Z     = 4,
  parameter int MB    = 4,
  parameter int ITERS = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic                                   out_ready,
  output logic                                   in_ready,
  output logic                                   ld_we,
  output logic [$clog2((INFO_E+MB)*Z)-1:0]       ld_addr,
  output logic                                   msg_clear,
  output logic                                   phase_a,
  output logic                                   phase_b,
  output logic [EW-1:0]                          eidx,
  output logic [((MB > 1) ? $clog2(MB) : 1)-1:0] brow,
  output logic                                   out_valid,
  output logic [$clog2(INFO_E+MB)-1:0]           out_blk,
  output logic                                   out_last,
  output logic                                   done
);
  localparam int NB   = INFO_E + MB;
  localparam int N    = NB * Z;
  localparam int NW   = $clog2(N);
  localparam int CB_W = $clog2(NB);
  localparam int RB_W = (MB > 1) ? $clog2(MB) : 1;
  localparam int IT_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  typedef enum logic [1:0] {S_LOAD, S_DEC, S_OUT} st_t;
  st_t st;
  logic            in_b;
  logic [IT_W-1:0] iter;

  assign in_ready  = (st == S_LOAD);
  assign ld_we     = in_ready && in_valid;
  assign msg_clear = ld_we && (ld_addr == NW'(N - 1));
  assign phase_a   = (st == S_DEC) && !in_b;
  assign phase_b   = (st == S_DEC) && in_b;
  assign out_valid = (st == S_OUT);
  assign out_last  = out_valid && (out_blk == CB_W'(NB - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_LOAD;
      ld_addr <= '0;
      in_b    <= 1'b0;
      eidx    <= '0;
      brow    <= '0;
      iter    <= '0;
      out_blk <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_LOAD: if (in_valid) begin
          if (ld_addr == NW'(N - 1)) begin
            ld_addr <= '0;
            st      <= S_DEC;
            in_b    <= 1'b0;
            eidx    <= '0;
            brow    <= '0;
            iter    <= '0;
          end else begin
            ld_addr <= ld_addr + NW'(1);
          end
        end
        S_DEC: begin
          if (eidx == EW'(ROW_W - 1)) begin
            eidx <= '0;
            in_b <= !in_b;
            if (in_b) begin
              if (brow == RB_W'(MB - 1)) begin
                brow <= '0;
                if (iter == IT_W'(ITERS - 1)) begin
                  iter <= '0;
                  st   <= S_OUT;
                  done <= 1'b1;
                end else begin
                  iter <= iter + IT_W'(1);
                end
              end else begin
                brow <= brow + RB_W'(1);
              end
            end
          end else begin
            eidx <= eidx + EW'(1);
          end
        end
        S_OUT: if (out_ready) begin
          if (out_blk == CB_W'(NB - 1)) begin
            out_blk <= '0;
            st      <= S_LOAD;
          end else begin
            out_blk <= out_blk + CB_W'(1);
          end
        end
        default: st <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/ldpc_layer_dec.sv
module ldpc_layer_dec
  import ldpc_layer_pkg::*;
#(
  parameter int Z     = 4,
  parameter int MB    = 4,
  parameter int ITERS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LLR_W-1:0] in_llr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [Z-1:0]     out_bits,
  output logic             out_last,
  output logic             done
);
  localparam int NB   = INFO_E + MB;
  localparam int N    = NB * Z;
  localparam int NW   = $clog2(N);
  localparam int CB_W = $clog2(NB);
  localparam int RB_W = (MB > 1) ? $clog2(MB) : 1;
  localparam int ZW   = (Z > 1) ? $clog2(Z) : 1;
  localparam int NR   = MB * Z;

  post_t post_mem [N];
  cmsg_t msg_mem  [NR];

  logic            ld_we, msg_clear, phase_a, phase_b;
  logic [NW-1:0]   ld_addr;
  logic [EW-1:0]   eidx;
  logic [RB_W-1:0] brow;
  logic [CB_W-1:0] out_blk;
  logic [CB_W-1:0] bcol;
  logic [ZW-1:0]   shift;

  logic [NW-1:0] paddr   [Z];
  post_t         lane_in [Z];
  post_t         lane_out[Z];
  cmsg_t         lane_old[Z];
  cmsg_t         lane_new[Z];

  ldpc_layer_ctrl #(.Z(Z), .MB(MB), .ITERS(ITERS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .ld_we(ld_we), .ld_addr(ld_addr), .msg_clear(msg_clear),
    .phase_a(phase_a), .phase_b(phase_b), .eidx(eidx), .brow(brow),
    .out_valid(out_valid), .out_blk(out_blk), .out_last(out_last), .done(done)
  );

  ldpc_layer_rom #(.Z(Z), .MB(MB)) u_rom (
    .brow(brow), .eidx(eidx), .bcol(bcol), .shift(shift)
  );

  for (genvar z = 0; z < Z; z++) begin : g_lane
    always_comb begin
      paddr[z]    = NW'(int'(bcol) * Z + ((z + int'(shift)) % Z));
      lane_in[z]  = post_mem[paddr[z]];
      lane_old[z] = msg_mem[int'(brow) * Z + z];
    end

    ldpc_layer_lane u_lane (
      .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
      .eidx(eidx), .post_in(lane_in[z]), .msg_old(lane_old[z]),
      .post_out(lane_out[z]), .msg_new(lane_new[z])
    );
  end

  // posterior store: loading writes one entry, phase B writes one per lane
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) post_mem[i] <= '0;
    end else if (ld_we) begin
      post_mem[ld_addr] <= {{(POST_W-LLR_W){in_llr[LLR_W-1]}}, in_llr};
    end else if (phase_b) begin
      for (int z = 0; z < Z; z++) post_mem[paddr[z]] <= lane_out[z];
    end
  end

  // compressed message store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) msg_mem[i] <= '0;
    end else if (msg_clear) begin
      for (int i = 0; i < NR; i++) msg_mem[i] <= '0;
    end else if (phase_b && eidx == '0) begin
      for (int z = 0; z < Z; z++) msg_mem[int'(brow) * Z + z] <= lane_new[z];
    end
  end

  always_comb begin
    for (int z = 0; z < Z; z++)
      out_bits[z] = post_mem[int'(out_blk) * Z + z][POST_W-1];
  end
endmodule

// File: rtl/ldpc_layer_chk.sv
module ldpc_layer_chk #(
  parameter int Z     = 4,
  parameter int MB    = 4,
  parameter int ITERS = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [Z-1:0] out_bits,
  input logic         out_last,
  input logic         done
);
  localparam int LAT = ITERS * MB * 12;
  int busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (!in_ready && !out_valid) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  assert_stream_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy_cnt == LAT);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_last)));

  assert_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_first_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_rise_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  logic unused_iv;
  assign unused_iv = in_valid;
endmodule

bind ldpc_layer_dec ldpc_layer_chk #(.Z(Z), .MB(MB), .ITERS(ITERS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
  .out_last(out_last), .done(done)
);

// File: tb/ldpc_layer_dec_bench.sv
module ldpc_layer_dec_bench;
  localparam int CLK_P = 10;
  localparam int Z     = 4;
  localparam int MB    = 4;
  localparam int ITERS = 3;
  localparam int W     = 6;
  localparam int KB    = 4;
  localparam int NB    = KB + MB;
  localparam int N     = NB * Z;
  localparam int NR    = MB * Z;
  localparam int LAT   = ITERS * MB * 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [5:0]   in_llr = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [Z-1:0] out_bits;
  logic         out_last;
  logic         done;

  ldpc_layer_dec #(.Z(Z), .MB(MB), .ITERS(ITERS)) u_ldpc_layer_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_llr(in_llr), .out_valid(out_valid), .out_ready(out_ready),
    .out_bits(out_bits), .out_last(out_last), .done(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int llr_q [N];
  bit exp_bits [N];
  bit prev_bits [N];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    if (x > 127) return 127;
    if (x < -127) return -127;
    return x;
  endfunction

  // connection rule of R6
  function automatic int var_of(input int r, input int z, input int e);
    int c, s;
    if (e < KB) begin c = e; s = (r * (e + 1) + e) % Z; end
    else if (e == KB) begin c = KB + r; s = 0; end
    else begin c = KB + ((r + MB - 1) % MB); s = 0; end
    return c * Z + (z + s) % Z;
  endfunction

  // bit-exact layered min-sum sweep (R2..R6)
  task automatic run_model();
    int p [N];
    int m1 [NR];
    int m2 [NR];
    int mi [NR];
    bit sg [NR][W];
    int q [W];
    bit qs [W];
    for (int i = 0; i < N; i++) p[i] = llr_q[i];
    for (int i = 0; i < NR; i++) begin
      m1[i] = 0; m2[i] = 0; mi[i] = 0;
      for (int e = 0; e < W; e++) sg[i][e] = 0;
    end
    for (int it = 0; it < ITERS; it++)
      for (int r = 0; r < MB; r++)
        for (int z = 0; z < Z; z++) begin
          int row, a1, a2, ai, mg;
          bit tot, ntot;
          row = r * Z + z;
          tot = 0;
          for (int e = 0; e < W; e++) tot ^= sg[row][e];
          a1 = 127; a2 = 127; ai = 0; ntot = 0;
          for (int e = 0; e < W; e++) begin
            int v, om;
            v  = var_of(r, z, e);
            om = (e == mi[row]) ? m2[row] : m1[row];
            if (tot ^ sg[row][e]) om = -om;
            q[e]  = sat(p[v] - om);
            qs[e] = (q[e] < 0);
            ntot ^= qs[e];
            mg = qs[e] ? -q[e] : q[e];
            if (mg < a1) begin a2 = a1; a1 = mg; ai = e; end
            else if (mg < a2) a2 = mg;
          end
          for (int e = 0; e < W; e++) begin
            int v, nm;
            v  = var_of(r, z, e);
            nm = (e == ai) ? a2 : a1;
            if (ntot ^ qs[e]) nm = -nm;
            p[v] = sat(q[e] + nm);
          end
          m1[row] = a1; m2[row] = a2; mi[row] = ai;
          for (int e = 0; e < W; e++) sg[row][e] = qs[e];
        end
    for (int i = 0; i < N; i++) exp_bits[i] = (p[i] < 0);
  endtask

  task automatic run_frame(input string tag);
    int t0, blk, k;
    bit held;
    logic [Z-1:0] hb, eb;
    run_model();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready while loading", int'(in_ready), 1);
      in_valid = 1'b1;
      in_llr   = llr_q[i][5:0];
    end
    @(negedge clk);
    t0 = cyc;
    chk(in_ready == 1'b0, "R1 closed after frame", int'(in_ready), 0);
    // keep pushing noise into the closed stream
    while (!out_valid) begin
      in_llr = 6'($urandom);
      if (in_ready) chk(1'b0, "R1 ready during decode", 1, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk((cyc - t0) == LAT, "R7 latency", cyc - t0, LAT);
    chk(done == 1'b1, "R9 done with first beat", int'(done), 1);
    blk = 0; k = 0; held = 0; hb = '0;
    while (blk < NB) begin
      bit rdy;
      if (k == 1) chk(done == 1'b0, "R9 single pulse", int'(done), 0);
      if (held) chk(out_bits == hb, "R8 hold under stall", int'(out_bits), int'(hb));
      chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
      rdy = (($urandom % 4) != 0);
      out_ready = rdy;
      if (rdy) begin
        for (int z = 0; z < Z; z++) eb[z] = exp_bits[blk * Z + z];
        chk(out_bits == eb, {tag, " R2 R4 R5 R6 beat data"}, int'(out_bits), int'(eb));
        chk(out_last == (blk == NB - 1), "R8 last flag", int'(out_last), int'(blk == NB - 1));
        for (int z = 0; z < Z; z++) prev_bits[blk * Z + z] = out_bits[z];
        blk++;
        held = 0;
      end else begin
        held = 1;
        hb   = out_bits;
      end
      k++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R8 input reopens", int'(in_ready), 1);
  endtask

  initial begin
    int agree;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R8 reset idle", int'(out_valid), 0);
    chk(done == 1'b0, "R9 reset quiet", int'(done), 0);
    rst_n = 1'b1;

    // R2: clean all-zero codeword, all decisions 0
    for (int i = 0; i < N; i++) llr_q[i] = 31;
    run_frame("R2 strong positive");
    // R3: extreme values drive the posteriors into saturation
    for (int i = 0; i < N; i++) llr_q[i] = -32;
    run_frame("R3 strong negative");
    for (int i = 0; i < N; i++) llr_q[i] = (i % 3 == 0) ? -32 : 31;
    run_frame("R3 mixed extremes");
    // R4: ties and zeros in the minima
    for (int i = 0; i < N; i++) llr_q[i] = (i % 2 == 0) ? 0 : 5;
    run_frame("R4 ties and zeros");
    // noisy all-zero codeword with a few flipped values
    for (int f = 0; f < 12; f++) begin
      for (int i = 0; i < N; i++) llr_q[i] = int'($urandom % 28) - 8;
      run_frame("R5 noisy codeword");
    end
    for (int f = 0; f < 6; f++) begin
      for (int i = 0; i < N; i++) llr_q[i] = int'($urandom % 64) - 32;
      run_frame("R6 random values");
    end
    // R10: repeat the last frame, decisions must match the earlier run
    run_frame("R10 repeat");
    agree = 1;
    for (int i = 0; i < N; i++) if (prev_bits[i] != exp_bits[i]) agree = 0;
    chk(agree == 1, "R10 repeatable frame", agree, 1);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule